// File: doc/BRIEF.md
# 8-bit Function-Coded ALU with Signed Compare

This block is the purely combinational arithmetic and logic unit of a small 8-bit processor datapath. It takes two 8-bit operands and a 3-bit function code. It returns an 8-bit result together with two comparison flags: equality and signed less-than. The same unit serves register-to-register operations, immediate operations (the decoder picks the function code) and branch decisions.

The comparison flags always come from a dedicated subtractor that computes operand A minus operand B. The function code does not affect them, so a branch unit can read them whatever operation the decoder selects. Signed less-than uses the sign of the difference corrected by the signed-overflow bit. This keeps it right when the subtraction overflows, for example when 0x7F is compared with 0x80. Shifts take their amount from the low three bits of operand B only.

Top module: `alu8_core`

## Requirements
- R1: Function code 3'b000 gives result = (A + B) mod 256; the carry out is dropped (0xFF + 0x01 gives 0x00).
- R2: Function code 3'b001 gives result = (A - B) mod 256 (0x00 - 0x01 gives 0xFF).
- R3: Function codes 3'b010, 3'b011 and 3'b100 give bitwise A AND B, A OR B and A XOR B respectively.
- R4: Function code 3'b101 shifts A left by B[2:0] positions and fills with zeros; B[7:3] have no effect on the result.
- R5: Function code 3'b110 shifts A right logically by B[2:0] positions and fills with zeros from the top; B[7:3] have no effect on the result.
- R6: Function code 3'b111 behaves as ADD: result = (A + B) mod 256.
- R7: flag_eq is 1 exactly when the 8-bit difference A - B is zero, that is when A equals B.
- R8: flag_lt is 1 exactly when A is less than B with both read as 8-bit two's-complement values, including overflow cases (A=0x7F, B=0x80 gives 0; A=0x80, B=0x7F gives 1).
- R9: flag_eq and flag_lt depend only on A and B, and are the same for every function code.
- R10: A shift (code 3'b101 or 3'b110) whose amount B[2:0] is zero returns A unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 8 | Operand A; the value that is shifted, and the minuend for compares |
| op_b | input | 8 | Operand B; supplies the shift amount in bits [2:0], and is the subtrahend for compares |
| func | input | 3 | Function code that selects the result operation |
| result | output | 8 | Result of the selected operation |
| flag_eq | output | 1 | A equals B, taken from the subtract path |
| flag_lt | output | 1 | A is less than B, signed, taken from the subtract path |

## Verification
All three outputs are combinational, so each is due in the same cycle as the operands and function code that produce it; no register lies on any path. The driver applies one stimulus just after a rising clock edge and queues the expected values. The monitor pops and compares half a period later, on the falling edge, after the logic has settled and well before the next stimulus. One item enters the queue per cycle, so stimulus and check stay paired with no latency to track. An exhaustive sweep of all operand pairs, with the function code rotating, covers the overflow corners of the signed compare and shows that the flags do not depend on the function code.

// File: rtl/alu8_pkg.sv
// Package: alu8_pkg
// Shared function-code encoding and flag bundle for the 8-bit ALU.
// Assumes the decoder drives these exact 3-bit codes.
package alu8_pkg;

    localparam int unsigned FN_W = 3;

    typedef enum logic [FN_W-1:0] {
        FN_ADD     = 3'b000,
        FN_SUB     = 3'b001,
        FN_AND     = 3'b010,
        FN_OR      = 3'b011,
        FN_XOR     = 3'b100,
        FN_SHL     = 3'b101,
        FN_SHR     = 3'b110,
        FN_ALT_ADD = 3'b111
    } alu_fn_e;

    typedef struct packed {
        logic eq;
        logic lt;
    } cmp_flags_t;

endpackage

// File: rtl/alu8_addsub.sv
// Module: alu8_addsub
// Ripple adder built bit by bit. SUBTRACT=1 turns it into A - B, computed
// as A + ~B + 1. It also reports signed overflow from the top two carries.
// Assumes WIDTH >= 2. The final carry feeds only the overflow bit.
module alu8_addsub #(
    parameter int unsigned WIDTH    = 8,
    parameter bit          SUBTRACT = 1'b0
) (
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    output logic [WIDTH-1:0] sum,
    output logic             ovf
);

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   carry;

    // Invert B and seed the carry when subtracting.
    always_comb begin
        b_eff    = SUBTRACT ? ~in_b : in_b;
        carry[0] = SUBTRACT;
    end

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_fa
            assign sum[i]     = in_a[i] ^ b_eff[i] ^ carry[i];
            assign carry[i+1] = (in_a[i] & b_eff[i]) | (carry[i] & (in_a[i] ^ b_eff[i]));
        end
    endgenerate

    // Signed overflow when the carry into the sign bit differs from the carry out.
    always_comb begin
        ovf = carry[WIDTH] ^ carry[WIDTH-1];
    end

endmodule

// File: rtl/alu8_shift.sv
// Module: alu8_shift
// Logarithmic shifter. Stage k moves the data by 2**k when bit k of the
// amount is set. SHIFT_LEFT picks the direction. Zeros fill in both
// directions, so right shifts are logical.
// Assumes WIDTH is a power of two.
module alu8_shift #(
    parameter int unsigned WIDTH      = 8,
    parameter bit          SHIFT_LEFT = 1'b1,
    localparam int unsigned AMT_W     = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data_in,
    input  logic [AMT_W-1:0] amount,
    output logic [WIDTH-1:0] data_out
);

    logic [WIDTH-1:0] stage [0:AMT_W];

    assign stage[0] = data_in;

    genvar k;
    generate
        for (k = 0; k < AMT_W; k++) begin : g_stage
            if (SHIFT_LEFT) begin : g_left
                assign stage[k+1] = amount[k] ? (stage[k] << (1 << k)) : stage[k];
            end else begin : g_right
                assign stage[k+1] = amount[k] ? (stage[k] >> (1 << k)) : stage[k];
            end
        end
    endgenerate

    assign data_out = stage[AMT_W];

endmodule

// File: rtl/alu8_cmp.sv
// Module: alu8_cmp
// Turns the A - B difference and its overflow bit into the flags.
// Equal means the difference is zero. Signed less-than is the sign of
// the difference XOR overflow, which stays right when A - B overflows.
module alu8_cmp
    import alu8_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] diff,
    input  logic             diff_ovf,
    output cmp_flags_t       flags
);

    // Build both flags from the subtraction outcome.
    always_comb begin
        flags.eq = ~|diff;
        flags.lt = diff[WIDTH-1] ^ diff_ovf;
    end

endmodule

// File: rtl/alu8_core.sv
// Module: alu8_core
// Combinational ALU. func selects the result operation. The compare flags
// always come from a separate A - B path and do not depend on func.
// Shift amounts use only op_b[AMT_W-1:0]. Code 3'b111 acts as ADD.
// Assumes WIDTH is a power of two. It has no clock and no reset.
module alu8_core
    import alu8_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [FN_W-1:0]  func,
    output logic [WIDTH-1:0] result,
    output logic             flag_eq,
    output logic             flag_lt
);

    localparam int unsigned AMT_W = $clog2(WIDTH);

    logic [WIDTH-1:0] sum_add;
    logic [WIDTH-1:0] sum_sub;
    logic [WIDTH-1:0] shl_out;
    logic [WIDTH-1:0] shr_out;
    logic             add_ovf;
    logic             sub_ovf;
    logic [AMT_W-1:0] shamt;
    cmp_flags_t       cmp;

    assign shamt = op_b[AMT_W-1:0];

    alu8_addsub #(.WIDTH(WIDTH), .SUBTRACT(1'b0)) u_add (
        .in_a (op_a),
        .in_b (op_b),
        .sum  (sum_add),
        .ovf  (add_ovf)
    );

    alu8_addsub #(.WIDTH(WIDTH), .SUBTRACT(1'b1)) u_sub (
        .in_a (op_a),
        .in_b (op_b),
        .sum  (sum_sub),
        .ovf  (sub_ovf)
    );

    alu8_shift #(.WIDTH(WIDTH), .SHIFT_LEFT(1'b1)) u_shl (
        .data_in  (op_a),
        .amount   (shamt),
        .data_out (shl_out)
    );

    alu8_shift #(.WIDTH(WIDTH), .SHIFT_LEFT(1'b0)) u_shr (
        .data_in  (op_a),
        .amount   (shamt),
        .data_out (shr_out)
    );

    alu8_cmp #(.WIDTH(WIDTH)) u_cmp (
        .diff     (sum_sub),
        .diff_ovf (sub_ovf),
        .flags    (cmp)
    );

    // Pick the result for the current function code.
    always_comb begin
        unique case (alu_fn_e'(func))
            FN_ADD:     result = sum_add;
            FN_SUB:     result = sum_sub;
            FN_AND:     result = op_a & op_b;
            FN_OR:      result = op_a | op_b;
            FN_XOR:     result = op_a ^ op_b;
            FN_SHL:     result = shl_out;
            FN_SHR:     result = shr_out;
            FN_ALT_ADD: result = sum_add;
            default:    result = sum_add;
        endcase
    end

    // Drive the flags from the subtract path for every function code.
    always_comb begin
        flag_eq = cmp.eq;
        flag_lt = cmp.lt;
    end

    // Check the datapath against plain operand arithmetic once inputs are known.
    always_comb begin
        if (!$isunknown({op_a, op_b, func})) begin
            if (func == FN_ADD)
                p_add_wraps_r1: assert (result == WIDTH'(op_a + op_b))
                    else $error("R1 add result mismatch");
            if (func == FN_SUB)
                p_sub_wraps_r2: assert (result == WIDTH'(op_a - op_b))
                    else $error("R2 sub result mismatch");
            if (func == FN_SHL)
                p_shl_amount_r4: assert (result == WIDTH'(op_a << shamt))
                    else $error("R4 left shift mismatch");
            if (func == FN_SHR && shamt != '0)
                p_shr_zero_fill_r5: assert (result[WIDTH-1] == 1'b0)
                    else $error("R5 right shift did not fill with zero");
            if (func == FN_ALT_ADD)
                p_alt_is_add_r6: assert (result == WIDTH'(op_a + op_b))
                    else $error("R6 spare code is not add");
            p_eq_flag_r7: assert (flag_eq == (op_a == op_b))
                else $error("R7 equal flag mismatch");
            p_signed_lt_r8: assert (flag_lt == ($signed(op_a) < $signed(op_b)))
                else $error("R8 signed less-than mismatch");
            if ((func == FN_SHL || func == FN_SHR) && shamt == '0)
                p_zero_shift_r10: assert (result == op_a)
                    else $error("R10 zero shift altered operand");
        end
    end

endmodule

// File: tb/sim_alu8_core.sv
// Scoreboard bench. The driver applies operands after a rising edge and
// queues the expected outputs. The monitor compares them on the falling edge.
module sim_alu8_core;

    logic       clk = 1'b0;
    logic [7:0] a = 8'h00;
    logic [7:0] b = 8'h00;
    logic [2:0] f = 3'b000;
    logic [7:0] res;
    logic       eq;
    logic       lt;

    always #5 clk = ~clk;

    alu8_core u0 (
        .op_a    (a),
        .op_b    (b),
        .func    (f),
        .result  (res),
        .flag_eq (eq),
        .flag_lt (lt)
    );

    typedef struct {
        logic [7:0] er;
        logic       ee;
        logic       el;
        string      req;
        string      freq;
    } item_t;

    item_t q[$];
    int    total = 0;
    int    bad   = 0;
    bit    done  = 1'b0;

    // Reference model written from the requirements.
    function automatic logic [7:0] model_res(input logic [7:0] x, input logic [7:0] y,
                                             input logic [2:0] fn);
        int unsigned s;
        s = y[2:0];
        case (fn)
            3'b000:  return 8'((int'(x) + int'(y)) % 256);
            3'b001:  return 8'((int'(x) - int'(y) + 256) % 256);
            3'b010:  return x & y;
            3'b011:  return x | y;
            3'b100:  return x ^ y;
            3'b101:  return 8'((int'(x) * (1 << s)) % 256);
            3'b110:  return 8'(int'(x) / (1 << s));
            default: return 8'((int'(x) + int'(y)) % 256);
        endcase
    endfunction

    function automatic logic model_lt(input logic [7:0] x, input logic [7:0] y);
        int sx;
        int sy;
        sx = (x >= 8'h80) ? int'(x) - 256 : int'(x);
        sy = (y >= 8'h80) ? int'(y) - 256 : int'(y);
        return sx < sy;
    endfunction

    task automatic send(input logic [7:0] ta, input logic [7:0] tb, input logic [2:0] tf,
                        input string req, input string freq = "");
        item_t it;
        @(posedge clk);
        a = ta;
        b = tb;
        f = tf;
        it.er   = model_res(ta, tb, tf);
        it.ee   = (ta == tb);
        it.el   = model_lt(ta, tb);
        it.req  = req;
        it.freq = freq;
        q.push_back(it);
    endtask

    task automatic check(input string req, input string what, input logic [7:0] act,
                         input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s a=%h b=%h f=%b actual=%h expected=%h",
                     req, what, a, b, f, act, exp);
        end
    endtask

    // Monitor: compare one queued item per falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                check(it.req, "result", res, it.er);
                check((it.freq == "") ? "R7" : it.freq, "flag_eq", {7'd0, eq}, {7'd0, it.ee});
                check((it.freq == "") ? "R8" : it.freq, "flag_lt", {7'd0, lt}, {7'd0, it.el});
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Driver.
    initial begin
        send(8'h00, 8'h00, 3'b000, "R1");          // idle state: zero operands
        send(8'h07, 8'h09, 3'b000, "R1");
        send(8'hFF, 8'h01, 3'b000, "R1");          // carry dropped
        send(8'h80, 8'h80, 3'b000, "R1");
        send(8'h09, 8'h07, 3'b001, "R2");
        send(8'h00, 8'h01, 3'b001, "R2");          // borrow wraps to FF
        send(8'h80, 8'h01, 3'b001, "R2");
        send(8'hA5, 8'h3C, 3'b010, "R3");
        send(8'hA5, 8'h3C, 3'b011, "R3");
        send(8'hA5, 8'h3C, 3'b100, "R3");
        send(8'h81, 8'h01, 3'b101, "R4");
        send(8'h0F, 8'h0B, 3'b101, "R4");          // B[7:3] ignored, shift by 3
        send(8'hFF, 8'hFF, 3'b101, "R4");          // shift by 7
        send(8'h80, 8'h07, 3'b110, "R5");
        send(8'hFF, 8'h0C, 3'b110, "R5");          // zero fill, shift by 4
        send(8'hF0, 8'hF9, 3'b110, "R5");          // B[7:3] ignored, shift by 1
        send(8'h40, 8'h45, 3'b111, "R6");
        send(8'hFF, 8'h02, 3'b111, "R6");
        send(8'h7F, 8'h80, 3'b001, "R2", "R8");    // overflow: not less
        send(8'h80, 8'h7F, 3'b001, "R2", "R8");    // overflow: less
        send(8'hFF, 8'h01, 3'b001, "R2", "R8");
        send(8'h01, 8'hFF, 3'b001, "R2", "R8");
        send(8'h3C, 8'h3C, 3'b001, "R2", "R7");
        // R9: flags under non-subtract codes
        send(8'h55, 8'h55, 3'b010, "R3", "R9");
        send(8'h80, 8'h7F, 3'b101, "R4", "R9");
        send(8'h7F, 8'h80, 3'b110, "R5", "R9");
        // R10: zero-amount shifts
        send(8'hC3, 8'hF8, 3'b101, "R10");
        send(8'hC3, 8'h08, 3'b110, "R10");
        send(8'h01, 8'h00, 3'b110, "R10");
        // Exhaustive operand sweep with the function code rotating (R7, R8, R9)
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 256; j++) begin
                send(8'(i), 8'(j), 3'((i + j) % 8), "R9");
            end
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule